// File: doc/BRIEF.md
# PLL Retune Sequencer

This block steps a clock generator through a change of its multiplier and divider settings without exposing downstream logic to an unstable oscillator. A new multiplier and divider value and a pending-change flag are presented to it. When the core signals that it has gone idle while a change is pending, the sequencer asks an external clock switch to move the system clock onto the reference clock, waits for the switch to confirm, and only then drives the new settings onto its applied outputs.

From the moment the sequence starts, a lock counter advances once per reference-clock cycle. When the counter reaches the programmed lock value, the sequencer releases the bypass request. Once the switch confirms the return to the oscillator, it issues a one-cycle wakeup pulse to the core. A phase output reports where the sequence stands. The whole block runs on the reference clock, which is the clock that stays alive while the oscillator is bypassed. A lock value near 512 gives the oscillator time to settle. With a few cycles of switch latency on each side, a retune costs roughly six cycles plus the lock value.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, `phase` is 0 (idle), `byp_req` and `wake` are low, and `app_mult`/`app_div` hold the parameters `RST_MULT`/`RST_DIV`.
- R2: A sequence starts only at a clock edge where `idle_stb` and `chg_pend` are both high while idle. Either one alone leaves `phase` at 0 and `byp_req` low.
- R3: `byp_req` rises at the start edge and stays high through the bypassing and locking phases. It is low in the restoring, done and idle phases.
- R4: The new settings reach `app_mult`/`app_div` at the edge where `byp_ack` is seen high in the bypassing phase, and that same edge moves the block to locking. If `byp_ack` is first driven high after start edge a, locking begins at edge a+1.
- R5: The lock counter is zero at the start edge and gains one per cycle. Locking ends at edge max(a+2, L+1) after the start edge, where L is `lock_cnt`. That is the first edge at which the block has spent a cycle in locking and the count has reached L.
- R6: With `lock_cnt` zero, locking ends after exactly one cycle.
- R7: In restoring, the block waits for `byp_ack` low. At the next edge it asserts `wake` for exactly one cycle (done phase) and then returns to idle.
- R8: `new_mult`/`new_div` are ignored except at the capture edge of R4. Changing them during locking leaves the applied outputs unchanged, and the applied values persist after the sequence.
- R9: `phase` encoding: 0 idle, 1 bypassing, 2 locking, 3 restoring, 4 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_cnt | input | LOCK_W | Programmed lock value in reference cycles |
| new_mult | input | MULT_W | Requested multiplier |
| new_div | input | DIV_W | Requested divider |
| chg_pend | input | 1 | A settings change is waiting |
| idle_stb | input | 1 | Core has entered idle |
| byp_ack | input | 1 | Clock switch reports reference clock selected |
| byp_req | output | 1 | Request to select the reference clock |
| app_mult | output | MULT_W | Multiplier applied to the oscillator |
| app_div | output | DIV_W | Divider applied to the oscillator |
| wake | output | 1 | One-cycle wakeup pulse to the core |
| phase | output | 3 | Current sequence phase |

## Verification
The hardest situation to reach is a switch latency long enough that the lock count has already been passed when locking begins. In that case the exit edge comes from the a+2 term of R5 rather than from the lock value. The bench models the clock switch itself and sweeps its assert and release latencies against small lock values, including zero, so that both terms of the maximum decide the exit edge. During locking it also changes the requested settings, to show that they do not reach the applied outputs.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_BYP  = 3'd1,
      PH_LOCK = 3'd2,
      PH_REST = 3'd3,
      PH_DONE = 3'd4
   } phase_t;
endpackage

// File: rtl/pll_retune_ctrl.sv
module pll_retune_ctrl
   import pll_retune_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   byp_ack,
   input  logic   expired,
   output phase_t state,
   output logic   byp_req,
   output logic   cnt_run,
   output logic   load,
   output logic   wake
);
   phase_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         PH_IDLE: if (start)    nxt = PH_BYP;
         PH_BYP:  if (byp_ack)  nxt = PH_LOCK;
         PH_LOCK: if (expired)  nxt = PH_REST;
         PH_REST: if (!byp_ack) nxt = PH_DONE;
         PH_DONE:               nxt = PH_IDLE;
         default:               nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PH_IDLE;
      else        state <= nxt;
   end

   assign byp_req = (state == PH_BYP) || (state == PH_LOCK);
   assign cnt_run = byp_req;
   assign load    = (state == PH_BYP) && byp_ack;
   assign wake    = (state == PH_DONE);

   // R7
   wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake && state == PH_IDLE);
   // R7
   wake_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_REST && !byp_ack) |=> wake);
   // R2
   no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_IDLE && !start) |=> state == PH_IDLE);
endmodule

// File: rtl/pll_retune_cnt.sv
module pll_retune_cnt #(
   parameter int LOCK_W  = 10,
   parameter bit SAT_CNT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [LOCK_W-1:0] limit,
   output logic              expired
);
   localparam int CW = LOCK_W + 1;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_inc;

   generate
      if (SAT_CNT) begin : g_sat
         assign cnt_inc = (cnt == CMAX) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= cnt_inc;
      else          cnt <= '0;
   end

   assign expired = cnt >= {1'b0, limit};

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt != CMAX) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/pll_retune_apply.sv
module pll_retune_apply #(
   parameter int                MULT_W   = 6,
   parameter int                DIV_W    = 3,
   parameter logic [MULT_W-1:0] RST_MULT = '0,
   parameter logic [DIV_W-1:0]  RST_DIV  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MULT_W-1:0] mult_in,
   input  logic [DIV_W-1:0]  div_in,
   output logic [MULT_W-1:0] mult_q,
   output logic [DIV_W-1:0]  div_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mult_q <= RST_MULT;
         div_q  <= RST_DIV;
      end else if (load) begin
         mult_q <= mult_in;
         div_q  <= div_in;
      end
   end

   // R8
   apply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mult_q) && $stable(div_q));
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
   import pll_retune_pkg::*;
#(
   parameter int                MULT_W   = 6,
   parameter int                DIV_W    = 3,
   parameter int                LOCK_W   = 10,
   parameter bit                SAT_CNT  = 1'b1,
   parameter logic [MULT_W-1:0] RST_MULT = 6'd10,
   parameter logic [DIV_W-1:0]  RST_DIV  = 3'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LOCK_W-1:0] lock_cnt,
   input  logic [MULT_W-1:0] new_mult,
   input  logic [DIV_W-1:0]  new_div,
   input  logic              chg_pend,
   input  logic              idle_stb,
   input  logic              byp_ack,
   output logic              byp_req,
   output logic [MULT_W-1:0] app_mult,
   output logic [DIV_W-1:0]  app_div,
   output logic              wake,
   output logic [2:0]        phase
);
   generate
      if (LOCK_W < 2 || LOCK_W > 24) begin : g_bad_lock
         $error("LOCK_W out of range");
      end
      if (MULT_W < 1 || DIV_W < 1) begin : g_bad_field
         $error("settings fields need at least one bit");
      end
   endgenerate

   phase_t state;
   logic   cnt_run, load, expired;

   pll_retune_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (idle_stb & chg_pend),
      .byp_ack (byp_ack),
      .expired (expired),
      .state   (state),
      .byp_req (byp_req),
      .cnt_run (cnt_run),
      .load    (load),
      .wake    (wake)
   );

   pll_retune_cnt #(.LOCK_W(LOCK_W), .SAT_CNT(SAT_CNT)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (cnt_run),
      .limit   (lock_cnt),
      .expired (expired)
   );

   pll_retune_apply #(
      .MULT_W(MULT_W), .DIV_W(DIV_W), .RST_MULT(RST_MULT), .RST_DIV(RST_DIV)
   ) u_apply (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .mult_in (new_mult),
      .div_in  (new_div),
      .mult_q  (app_mult),
      .div_q   (app_div)
   );

   assign phase = state;

   // R5
   restore_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_LOCK && !expired) |=> state == PH_LOCK);
   // R4
   lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_BYP && !byp_ack) |=> state == PH_BYP);
endmodule

// File: tb/pll_retune_seq_bench.sv
module pll_retune_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] lock_cnt = '0;
   logic [5:0] new_mult = '0;
   logic [2:0] new_div = '0;
   logic       chg_pend = 1'b0, idle_stb = 1'b0, byp_ack = 1'b0;
   logic       byp_req, wake;
   logic [5:0] app_mult;
   logic [2:0] app_div;
   logic [2:0] phase;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pll_retune_seq u_pll_retune_seq (
      .clk(clk), .rst_n(rst_n), .lock_cnt(lock_cnt), .new_mult(new_mult),
      .new_div(new_div), .chg_pend(chg_pend), .idle_stb(idle_stb),
      .byp_ack(byp_ack), .byp_req(byp_req), .app_mult(app_mult),
      .app_div(app_div), .wake(wake), .phase(phase)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // one retune: lock value L, ack after start edge a, release b cycles after restore
   task automatic run_seq(input int L, input int a, input int b,
                          input logic [5:0] m, input logic [2:0] d);
      int t_lock = -1, t_rst = -1, t_wake = -1, ek;
      bit byp_bad = 1'b0, app_bad = 1'b0;
      logic [5:0] om = app_mult;
      logic [2:0] od = app_div;
      ek = (a + 2 > L + 1) ? a + 2 : L + 1;
      lock_cnt = 10'(L); new_mult = m; new_div = d;
      chg_pend = 1'b1; idle_stb = 1'b1;
      step();
      idle_stb = 1'b0; chg_pend = 1'b0;
      chk(phase == 3'd1 && byp_req, "R3 start", int'(phase), 1);
      chk(app_mult == om && app_div == od, "R4 early apply", int'(app_mult), int'(om));
      for (int j = 0; j < 3000; j++) begin
         if ((phase == 3'd1 || phase == 3'd2) && !byp_req) byp_bad = 1'b1;
         if ((phase == 3'd3 || phase == 3'd4) && byp_req)  byp_bad = 1'b1;
         if (phase == 3'd1 && (app_mult != om || app_div != od)) app_bad = 1'b1;
         if (phase == 3'd2 && t_lock < 0) begin
            t_lock = j;
            chk(app_mult == m && app_div == d, "R4 apply", int'(app_mult), int'(m));
         end
         if (phase == 3'd2) begin
            new_mult = ~m; new_div = ~d;
         end
         if (phase == 3'd3 && t_rst < 0) t_rst = j;
         if (wake && t_wake < 0) t_wake = j;
         if (t_wake >= 0 && j == t_wake + 1) begin
            chk(phase == 3'd0 && !wake, "R7 pulse end", int'(phase), 0);
            break;
         end
         if (j == a) byp_ack = 1'b1;
         if (t_rst >= 0 && j == t_rst + b) byp_ack = 1'b0;
         step();
      end
      chk(t_lock == a + 1, "R4 lock edge", t_lock, a + 1);
      chk(t_rst == ek, (L == 0) ? "R6 zero lock exit" : "R5 lock exit", t_rst, ek);
      chk(t_wake == ek + b + 1, "R7 wake edge", t_wake, ek + b + 1);
      chk(!byp_bad, "R3 bypass level", int'(byp_bad), 0);
      chk(!app_bad, "R4 no early apply", int'(app_bad), 0);
      chk(app_mult == m && app_div == d, "R8 settings persist", int'(app_mult), int'(m));
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R1 reset state
      chk(phase == 3'd0 && !byp_req && !wake, "R1 reset ctl", int'(phase), 0);
      chk(app_mult == 6'd10 && app_div == 3'd0, "R1 reset apply", int'(app_mult), 10);
      rst_n = 1'b1;
      step();
      // R2 lone strobe and lone pending flag
      idle_stb = 1'b1; step(); idle_stb = 1'b0;
      chk(phase == 3'd0 && !byp_req, "R2 strobe alone", int'(phase), 0);
      chg_pend = 1'b1; step(); step(); chg_pend = 1'b0;
      chk(phase == 3'd0 && !byp_req, "R2 pending alone", int'(phase), 0);
      chk(app_mult == 6'd10, "R2 apply untouched", int'(app_mult), 10);
      // sweep: R5 R6 R9 phase order 1,2,3,4,0
      for (int li = 0; li < 6; li++) begin
         for (int ai = 0; ai < 3; ai++) begin
            for (int bi = 0; bi < 2; bi++) begin
               int lv = (li == 5) ? 8 : li;
               int av = (ai == 2) ? 6 : ai;
               run_seq(lv, av, bi * 2, 6'(li * 7 + ai * 3 + bi + 1), 3'(li + ai));
            end
         end
      end
      // default-size lock window
      run_seq(512, 4, 2, 6'd33, 3'd5);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule